// File: doc/BRIEF.md
# CAN Acceptance Filter and Mask Unit

This block sits behind a CAN receiver. For every frame that the receiver has found complete and free of errors, it decides whether the frame is kept and which of two receive buffers it lands in. Six programmable filters are split into two groups. Filters 0 and 1 share mask 0 and feed buffer 0. Filters 2 to 5 share mask 1 and feed buffer 1. An extended frame is compared on its 29-bit identifier. A standard data frame is compared on a 29-bit key built from the 11-bit identifier followed by its first two data bytes.

Each buffer has a full flag. The flag is set when a frame is loaded and stays set until the host clears it. A frame aimed at a full buffer either rolls over from buffer 0 into buffer 1 or is dropped, and a drop raises the overflow flag of the intended buffer. Masks, filters and the rollover enable are written through a simple synchronous register write port.

Top module: `can_accept_unit`

## Requirements
- R1: After reset, accept_o, full_o, ovf_o and irq_o are 0. Every mask, every filter and the rollover enable are 0.
- R2: A mask bit of 1 requires the filter bit and the key bit to be equal. A mask bit of 0 makes that bit a don't-care.
- R3: The key of an extended frame (frame_ext_i=1) is frame_id_i[28:0]. A filter matches only frames whose type equals the filter's extended enable bit.
- R4: The key of a standard frame is {frame_id_i[10:0], 2'b00, frame_d0_i, frame_d1_i}, with the identifier in key bits 28:18. For a standard remote frame (frame_rtr_i=1), key bits 17:0 are don't-care.
- R5: Filters 0 and 1 use mask 0 and target buffer 0. Filters 2 to 5 use mask 1 and target buffer 1.
- R6: When several filters match, the lowest index wins. That index is reported on hit_idx_o, and its group sets the target buffer.
- R7: Results appear one clock after a cycle with frame_valid_i=1. accept_o pulses for exactly that one cycle, and only when the frame was loaded. No frame is evaluated while frame_valid_i=0.
- R8: Loading a frame sets full_o[buf_sel_o]. A full flag stays set until clr_i of that buffer is 1. irq_o is 1 whenever any full flag is set.
- R9: A frame that targets buffer 0 while buffer 0 is full goes to buffer 1 if rollover is enabled and buffer 1 is free. hit_idx_o still reports the matching filter.
- R10: A matching frame with no free buffer is dropped. accept_o stays 0, the full flags do not change, and ovf_o of the target buffer is set. clr_i also clears ovf_o.
- R11: Write map (wr_data_i bit 29 = extended enable, bits 28:0 = value): addresses 0 to 5 are filters, 8 is mask 0, 9 is mask 1, and 15 is config, where bit 0 is the rollover enable. Writes to any other address have no effect.
- R12: A clr_i in the same cycle as a frame strobe takes effect first, so the cleared buffer can take that frame. When a load and a clear hit the same buffer, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 30 | Register write data |
| frame_valid_i | input | 1 | Strobe for a complete, error-free frame |
| frame_ext_i | input | 1 | 1 = extended identifier |
| frame_rtr_i | input | 1 | 1 = remote frame |
| frame_id_i | input | 29 | Received identifier (standard in bits 10:0) |
| frame_d0_i | input | 8 | First data byte |
| frame_d1_i | input | 8 | Second data byte |
| clr_i | input | 2 | Host clear of full and overflow, one bit per buffer |
| accept_o | output | 1 | Frame loaded (one-cycle pulse) |
| hit_idx_o | output | 3 | Index of the winning filter |
| buf_sel_o | output | 1 | Buffer that was loaded |
| full_o | output | 2 | Full flags, one per buffer |
| ovf_o | output | 2 | Overflow flags, one per buffer |
| irq_o | output | 1 | Common interrupt: some buffer is full |

## Verification
The assertions take two things for granted. First, frame_valid_i is low throughout reset. Second, the frame fields are stable in every cycle in which frame_valid_i is high. They also rely on the host clearing a buffer only through clr_i, so a full flag can only fall in a cycle where its clear bit was high. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. Register writes are kept apart from frame strobes, so no frame is judged against a half-written filter set.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int ID_W     = 29;
  localparam int STD_W    = 11;
  localparam int BYTE_W   = 8;
  localparam int NUM_FLT  = 6;
  localparam int GRP0_N   = 2;
  localparam int NUM_BUF  = 2;
  localparam int IDX_W    = $clog2(NUM_FLT);
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = ID_W + 1;
  localparam int MASK_BASE = 8;
  localparam int CFG_ADDR  = 15;

  typedef struct packed {
    logic            ext;
    logic [ID_W-1:0] val;
  } flt_t;
endpackage

// File: rtl/can_acf_regs.sv
module can_acf_regs
  import can_acf_pkg::*;
#(
  parameter int N_FLT  = NUM_FLT,
  parameter int N_MASK = NUM_BUF,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int MBASE  = MASK_BASE,
  parameter int CADDR  = CFG_ADDR
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output flt_t [N_FLT-1:0]           flt_o,
  output logic [N_MASK-1:0][ID_W-1:0] mask_o,
  output logic                       rollover_o
);
  localparam int EXT_BIT = DW - 1;

  for (genvar i = 0; i < N_FLT; i++) begin : g_flt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flt_o[i] <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(i)) begin
        flt_o[i].ext <= wr_data_i[EXT_BIT];
        flt_o[i].val <= wr_data_i[ID_W-1:0];
      end
    end
  end

  for (genvar m = 0; m < N_MASK; m++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[m] <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(MBASE + m)) begin
        mask_o[m] <= wr_data_i[ID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rollover_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == AW'(CADDR)) begin
      rollover_o <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/can_acf_match.sv
module can_acf_match
  import can_acf_pkg::*;
#(
  parameter int N_FLT = NUM_FLT,
  parameter int G0_N  = GRP0_N
) (
  input  logic                          ext_i,
  input  logic                          rtr_i,
  input  logic [ID_W-1:0]               id_i,
  input  logic [BYTE_W-1:0]             d0_i,
  input  logic [BYTE_W-1:0]             d1_i,
  input  flt_t [N_FLT-1:0]              flt_i,
  input  logic [NUM_BUF-1:0][ID_W-1:0]  mask_i,
  output logic [N_FLT-1:0]              hit_o
);
  localparam int PAD_W  = ID_W - STD_W - 2 * BYTE_W;
  localparam int TAIL_W = ID_W - STD_W;

  logic [ID_W-1:0] key;
  logic [ID_W-1:0] care;

  // standard frames: identifier on top, data bytes in the bits an 11-bit id leaves free
  always_comb begin
    if (ext_i) begin
      key  = id_i;
      care = '1;
    end else begin
      key  = {id_i[STD_W-1:0], {PAD_W{1'b0}}, d0_i, d1_i};
      care = rtr_i ? {{STD_W{1'b1}}, {TAIL_W{1'b0}}} : '1;
    end
  end

  for (genvar i = 0; i < N_FLT; i++) begin : g_cmp
    localparam int GRP = (i < G0_N) ? 0 : 1;
    logic [ID_W-1:0] diff;
    assign diff     = (key ^ flt_i[i].val) & mask_i[GRP] & care;
    assign hit_o[i] = (flt_i[i].ext == ext_i) && (diff == '0);
  end
endmodule

// File: rtl/can_acf_steer.sv
module can_acf_steer
  import can_acf_pkg::*;
#(
  parameter int N_FLT = NUM_FLT,
  parameter int G0_N  = GRP0_N,
  parameter int IW    = IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_FLT-1:0]   hit_i,
  input  logic               rollover_i,
  input  logic [NUM_BUF-1:0] clr_i,
  output logic               accept_o,
  output logic [IW-1:0]      hit_idx_o,
  output logic               buf_sel_o,
  output logic [NUM_BUF-1:0] full_o,
  output logic [NUM_BUF-1:0] ovf_o
);
  logic [IW-1:0]      win_idx;
  logic               any_hit;
  logic               tgt;
  logic [NUM_BUF-1:0] full_eff, ovf_eff;
  logic [NUM_BUF-1:0] load, ovf_set;
  logic               sel;

  always_comb begin
    win_idx = '0;
    for (int i = N_FLT - 1; i >= 0; i--) begin
      if (hit_i[i]) win_idx = IW'(i);
    end
  end

  assign any_hit  = |hit_i;
  assign tgt      = (win_idx >= IW'(G0_N));
  assign full_eff = full_o & ~clr_i;
  assign ovf_eff  = ovf_o & ~clr_i;

  always_comb begin
    load    = '0;
    ovf_set = '0;
    sel     = 1'b0;
    if (valid_i && any_hit) begin
      if (!tgt) begin
        if (!full_eff[0]) begin
          load[0] = 1'b1;
        end else if (rollover_i && !full_eff[1]) begin
          load[1] = 1'b1;
          sel     = 1'b1;
        end else begin
          ovf_set[0] = 1'b1;
        end
      end else begin
        if (!full_eff[1]) begin
          load[1] = 1'b1;
          sel     = 1'b1;
        end else begin
          ovf_set[1] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      hit_idx_o <= '0;
      buf_sel_o <= 1'b0;
      full_o    <= '0;
      ovf_o     <= '0;
    end else begin
      accept_o <= |load;
      if (|load) begin
        hit_idx_o <= win_idx;
        buf_sel_o <= sel;
      end
      full_o <= full_eff | load;
      ovf_o  <= ovf_eff | ovf_set;
    end
  end
endmodule

// File: rtl/can_accept_unit.sv
module can_accept_unit
  import can_acf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 frame_valid_i,
  input  logic                 frame_ext_i,
  input  logic                 frame_rtr_i,
  input  logic [ID_W-1:0]      frame_id_i,
  input  logic [BYTE_W-1:0]    frame_d0_i,
  input  logic [BYTE_W-1:0]    frame_d1_i,
  input  logic [NUM_BUF-1:0]   clr_i,
  output logic                 accept_o,
  output logic [IDX_W-1:0]     hit_idx_o,
  output logic                 buf_sel_o,
  output logic [NUM_BUF-1:0]   full_o,
  output logic [NUM_BUF-1:0]   ovf_o,
  output logic                 irq_o
);
  flt_t [NUM_FLT-1:0]          flt;
  logic [NUM_BUF-1:0][ID_W-1:0] mask;
  logic                        rollover;
  logic [NUM_FLT-1:0]          hit;

  can_acf_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .flt_o      (flt),
    .mask_o     (mask),
    .rollover_o (rollover)
  );

  can_acf_match u_match (
    .ext_i  (frame_ext_i),
    .rtr_i  (frame_rtr_i),
    .id_i   (frame_id_i),
    .d0_i   (frame_d0_i),
    .d1_i   (frame_d1_i),
    .flt_i  (flt),
    .mask_i (mask),
    .hit_o  (hit)
  );

  can_acf_steer u_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (frame_valid_i),
    .hit_i      (hit),
    .rollover_i (rollover),
    .clr_i      (clr_i),
    .accept_o   (accept_o),
    .hit_idx_o  (hit_idx_o),
    .buf_sel_o  (buf_sel_o),
    .full_o     (full_o),
    .ovf_o      (ovf_o)
  );

  assign irq_o = |full_o;
endmodule

// File: rtl/can_accept_unit_chk.sv
module can_accept_unit_chk
  import can_acf_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_valid_i,
  input logic [NUM_BUF-1:0] clr_i,
  input logic               accept_o,
  input logic [IDX_W-1:0]   hit_idx_o,
  input logic               buf_sel_o,
  input logic [NUM_BUF-1:0] full_o
);
  a_r7_accept_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(frame_valid_i));

  a_r7_idle_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !accept_o);

  a_r8_full0_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o[0] && !clr_i[0] |=> full_o[0]);

  a_r8_full1_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o[1] && !clr_i[1] |=> full_o[1]);

  a_r8_accept_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> full_o[buf_sel_o]);

  a_r5_group1_to_buf1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && hit_idx_o >= IDX_W'(GRP0_N) |-> buf_sel_o);

  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> hit_idx_o < IDX_W'(NUM_FLT));

  a_r10_no_load_into_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && !buf_sel_o |-> !($past(full_o[0]) && !$past(clr_i[0])));
endmodule

bind can_accept_unit can_accept_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .clr_i         (clr_i),
  .accept_o      (accept_o),
  .hit_idx_o     (hit_idx_o),
  .buf_sel_o     (buf_sel_o),
  .full_o        (full_o)
);

// File: tb/sim_can_accept_unit.sv
`timescale 1ns/1ps
module sim_can_accept_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic        fv = 1'b0, fext = 1'b0, frtr = 1'b0;
  logic [28:0] fid = '0;
  logic [7:0]  fd0 = '0, fd1 = '0;
  logic [1:0]  clr = '0;
  logic        accept, buf_sel, irq;
  logic [2:0]  hit_idx;
  logic [1:0]  full, ovf;

  always #2.5 clk = ~clk;

  can_accept_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .frame_valid_i(fv), .frame_ext_i(fext), .frame_rtr_i(frame_rtr_sel()), .frame_id_i(fid),
    .frame_d0_i(fd0), .frame_d1_i(fd1), .clr_i(clr), .accept_o(accept), .hit_idx_o(hit_idx),
    .buf_sel_o(buf_sel), .full_o(full), .ovf_o(ovf), .irq_o(irq)
  );

  function automatic logic frame_rtr_sel();
    return frtr;
  endfunction

  typedef struct packed {
    logic       acc;
    logic [2:0] idx;
    logic       sel;
    logic [1:0] full;
    logic [1:0] ovf;
    logic       irq;
  } exp_t;

  int total = 0, bad = 0;
  exp_t exp_q[$];
  string tag_q[$];

  // shadow configuration and buffer state
  logic [28:0] m_flt[6];
  logic        m_ext[6];
  logic [28:0] m_mask[2];
  logic        m_roll = 1'b0;
  logic [1:0]  m_full = '0, m_ovf = '0;

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [29:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4'd6) begin
      m_flt[a] = d[28:0]; m_ext[a] = d[29];
    end else if (a == 4'd8 || a == 4'd9) begin
      m_mask[a-4'd8] = d[28:0];
    end else if (a == 4'd15) begin
      m_roll = d[0];
    end
  endtask

  function automatic exp_t predict(logic ext, logic rtr, logic [28:0] id,
                                   logic [7:0] d0, logic [7:0] d1, logic [1:0] c);
    exp_t e;
    logic [28:0] key, care;
    int win;
    logic [1:0] fe;
    win = -1;
    key  = ext ? id : {id[10:0], 2'b00, d0, d1};
    care = (!ext && rtr) ? {11'h7ff, 18'h0} : {29{1'b1}};
    for (int i = 5; i >= 0; i--) begin
      if (m_ext[i] == ext && (((key ^ m_flt[i]) & m_mask[(i < 2) ? 0 : 1] & care) == '0))
        win = i;
    end
    fe = m_full & ~c;
    e.ovf = m_ovf & ~c;
    e.acc = 1'b0; e.idx = '0; e.sel = 1'b0;
    if (win >= 0) begin
      if (win < 2) begin
        if (!fe[0]) begin e.acc = 1'b1; fe[0] = 1'b1; end
        else if (m_roll && !fe[1]) begin e.acc = 1'b1; e.sel = 1'b1; fe[1] = 1'b1; end
        else e.ovf[0] = 1'b1;
      end else begin
        if (!fe[1]) begin e.acc = 1'b1; e.sel = 1'b1; fe[1] = 1'b1; end
        else e.ovf[1] = 1'b1;
      end
      e.idx = 3'(win);
    end
    if (!e.acc) begin e.idx = '0; e.sel = 1'b0; end
    e.full = fe;
    e.irq = |fe;
    return e;
  endfunction

  task automatic send(string req, logic ext, logic rtr, logic [28:0] id,
                      logic [7:0] d0, logic [7:0] d1, logic [1:0] c = 2'b00);
    exp_t e;
    @(negedge clk);
    fv = 1'b1; fext = ext; frtr = rtr; fid = id; fd0 = d0; fd1 = d1; clr = c;
    e = predict(ext, rtr, id, d0, d1, c);
    exp_q.push_back(e); tag_q.push_back(req);
    m_full = e.full; m_ovf = e.ovf;
    @(negedge clk);
    fv = 1'b0; clr = 2'b00;
  endtask

  task automatic clear(logic [1:0] c);
    @(negedge clk);
    clr = c;
    m_full &= ~c; m_ovf &= ~c;
    @(negedge clk);
    clr = 2'b00;
  endtask

  task automatic check_state(string req);
    check(req, {10'b0, full, ovf, irq, accept}, {10'b0, m_full, m_ovf, |m_full, 1'b0});
  endtask

  // monitor: result is registered, valid one edge after the strobe edge
  always @(posedge clk) begin
    if (rst_n && fv) begin
      exp_t e, a;
      string t;
      #1;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a.acc = accept;
      a.idx = accept ? hit_idx : 3'd0;
      a.sel = accept ? buf_sel : 1'b0;
      a.full = full; a.ovf = ovf; a.irq = irq;
      check(t, 16'(a), 16'(e));
    end
  end

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_flt[i] = '0; m_ext[i] = 1'b0; end
    m_mask[0] = '0; m_mask[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // R1: all-zero masks and filters accept any standard frame via filter 0
    send("R1 zero config", 1'b0, 1'b0, 29'h7FF, 8'h12, 8'h34);
    clear(2'b01);

    // R11: configuration through the write port
    wr(4'd0, {1'b0, 11'h123, 2'b00, 8'hAA, 8'h55});
    wr(4'd1, {1'b1, 29'h1ABCDE12});
    wr(4'd2, {1'b0, 11'h200, 18'h0});
    wr(4'd3, {1'b1, 29'h0AB00000});
    wr(4'd4, {1'b0, 11'h120, 18'h0});
    wr(4'd5, {1'b0, 11'h205, 18'h0});
    wr(4'd8, {1'b0, 29'h1FFFFFFF});
    wr(4'd9, {1'b0, 11'h7F0, 18'h0});

    send("R4 std data exact", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    clear(2'b01);
    send("R4 R5 data byte miss to grp1", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h56);
    clear(2'b10);
    send("R4 remote ignores data", 1'b0, 1'b1, 29'h123, 8'hAA, 8'h56);
    clear(2'b01);
    send("R3 ext exact", 1'b1, 1'b0, 29'h1ABCDE12, 8'h00, 8'h00);
    clear(2'b01);
    send("R3 ext type mismatch", 1'b1, 1'b0, {11'h123, 18'h0}, 8'hAA, 8'h55);
    send("R2 ext dont care bits", 1'b1, 1'b0, 29'h0AB3FFFF, 8'h00, 8'h00);
    clear(2'b10);
    send("R6 lowest index wins", 1'b0, 1'b0, 29'h20A, 8'h00, 8'h00);
    send("R10 buf1 full drop", 1'b0, 1'b0, 29'h20B, 8'h00, 8'h00);
    check_state("R10 full unchanged");
    clear(2'b10);
    check_state("R8 clear");

    send("R8 load buf0", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    @(negedge clk);
    check_state("R8 full holds");
    send("R10 buf0 full no rollover", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    wr(4'd15, 30'h1);
    send("R9 rollover to buf1", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    send("R9 R10 both full", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    clear(2'b11);
    check_state("R10 clr clears ovf");

    // R11: unmapped addresses leave the filter set untouched
    wr(4'd12, {30{1'b1}});
    wr(4'd6, {30{1'b1}});
    send("R11 unmapped ignored", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55);
    // R12: same-cycle clear frees the buffer for the frame
    send("R12 clear and load", 1'b0, 1'b0, 29'h123, 8'hAA, 8'h55, 2'b01);

    // R7: no evaluation without strobe
    @(negedge clk);
    fid = 29'h123; fd0 = 8'hAA; fd1 = 8'h55; fext = 1'b0; frtr = 1'b0; clr = 2'b01;
    @(negedge clk);
    clr = 2'b00; m_full &= 2'b10; m_ovf &= 2'b10;
    check_state("R7 no strobe no load");

    repeat (3) @(negedge clk);
    check("R7 queue drained", 16'(exp_q.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule